// File: doc/BRIEF.md
# Priority interrupt acceptance controller

This block sits between the interrupt sources of a processor and its exception sequencer, and decides in each cycle whether an interrupt is taken and which one. It handles three kinds of source. The first is a non-maskable request at level 16. The second is a pair of debug sources, breakpoint and debug port, both fixed at level 15. The third is a parameterised set of external or peripheral lines, each with a programmable 4-bit level. The current 4-bit interrupt mask from the status register is compared against every pending maskable request. The highest eligible level wins, and ties go to the lowest source ID.

When a request is taken, the block raises a one-cycle accept strobe. Together with the strobe it gives the source ID, a vector index for the handler table, and the 4-bit value the CPU writes back into the mask field. Level 16 cannot be held in a 4-bit mask, so it is written as 4'hF. After an acceptance the block takes no further request until the CPU returns an acknowledge, which it does once it has taken the exception. Saving state, fetching the vector and controlling the pipeline belong to the CPU.

Top module: `irq_accept_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, accept is 0 and accept_id, accept_vec and new_mask are all 0.
- R2: A non-maskable request (source ID 0, level 16) is accepted for every sr_mask value, including 4'hF.
- R3: The breakpoint source (ID 1) and the debug-port source (ID 2) have level 15. Each is accepted when sr_mask is below 15 and is not accepted when sr_mask is 15.
- R4: External line k has source ID 3+k and takes its level from ext_lvl[4k+3:4k]. It is accepted only when that level is strictly greater than sr_mask.
- R5: An external line programmed to level 0 is never accepted.
- R6: When several eligible requests are pending, the one with the highest level is accepted.
- R7: When eligible requests share the highest level, the one with the lowest source ID is accepted.
- R8: On acceptance, new_mask equals the accepted level. For the non-maskable source, new_mask is 4'hF.
- R9: On acceptance, accept_vec equals 8 + accept_id.
- R10: Requests and sr_mask are sampled at a rising edge, and accept is high for exactly the following cycle. accept_id, accept_vec and new_mask keep their values until the next acceptance.
- R11: After an acceptance, no further request is accepted until cpu_ack has been sampled high. The earliest next accept strobe follows the clock edge after the edge that sampled cpu_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, level 16 |
| brk_req | input | 1 | Breakpoint request, fixed level 15 |
| dbg_req | input | 1 | Debug-port request, fixed level 15 |
| ext_req | input | N_EXT | External/peripheral request lines |
| ext_lvl | input | 4*N_EXT | Programmed level per external line, 4 bits each |
| sr_mask | input | 4 | Current interrupt mask from the status register |
| cpu_ack | input | 1 | CPU has taken the exception; re-enables acceptance |
| accept | output | 1 | One-cycle acceptance strobe |
| accept_id | output | ID_W | Accepted source ID |
| accept_vec | output | VEC_W | Vector table index of the accepted source |
| new_mask | output | 4 | Value to load into the status-register mask |

## Verification
Every result of this block is registered once. A request pattern driven before a rising edge shows up as accept, accept_id, accept_vec and new_mask right after that edge. The bench drives inputs on falling edges and reads the outputs at the next falling edge, one cycle later. Rejections are checked over two such sample points, so that a strobe that arrives late is also caught. For the hold-off, the bench counts edges explicitly. It holds cpu_ack for one cycle and expects accept to stay low at the sample point after that edge and to rise at the following one.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVL_W = 4;
  localparam int PRI_W = LVL_W + 1;
  localparam int N_FIXED = 3;

  localparam logic [PRI_W-1:0] PRI_NMI = PRI_W'(16);
  localparam logic [PRI_W-1:0] PRI_DEBUG = PRI_W'(15);

  // A request is eligible when its priority is strictly above the mask.
  function automatic logic beats_mask(input logic [PRI_W-1:0] pri,
                                      input logic [LVL_W-1:0] mask);
    return pri > {1'b0, mask};
  endfunction

  // Level 16 does not fit the 4-bit mask field; saturate it to 15.
  function automatic logic [LVL_W-1:0] mask_from_pri(input logic [PRI_W-1:0] pri);
    return pri[LVL_W] ? {LVL_W{1'b1}} : pri[LVL_W-1:0];
  endfunction
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_accept_pkg::*;
#(
  parameter int N_EXT = 8,
  localparam int N_SRC = N_FIXED + N_EXT
) (
  input  logic                         nmi_req,
  input  logic                         brk_req,
  input  logic                         dbg_req,
  input  logic [N_EXT-1:0]             ext_req,
  input  logic [N_EXT*LVL_W-1:0]       ext_lvl,
  output logic [N_SRC-1:0]             src_req,
  output logic [N_SRC-1:0][PRI_W-1:0]  src_pri
);
  // Fixed sources occupy IDs 0..2 in tie-break order.
  assign src_req[0] = nmi_req;
  assign src_pri[0] = PRI_NMI;
  assign src_req[1] = brk_req;
  assign src_pri[1] = PRI_DEBUG;
  assign src_req[2] = dbg_req;
  assign src_pri[2] = PRI_DEBUG;

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    assign src_req[N_FIXED+k] = ext_req[k];
    assign src_pri[N_FIXED+k] = {1'b0, ext_lvl[k*LVL_W +: LVL_W]};
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_accept_pkg::*;
#(
  parameter int N_SRC = 11,
  parameter int ID_W  = 4
) (
  input  logic [N_SRC-1:0]             src_req,
  input  logic [N_SRC-1:0][PRI_W-1:0]  src_pri,
  input  logic [LVL_W-1:0]             sr_mask,
  output logic                         pick_valid,
  output logic [ID_W-1:0]              pick_id,
  output logic [PRI_W-1:0]             pick_pri
);
  logic [N_SRC-1:0] eligible;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign eligible[i] = src_req[i] && beats_mask(src_pri[i], sr_mask);
  end

  // Strict ">" keeps the earliest (lowest ID) source on equal priority.
  always_comb begin
    pick_valid = 1'b0;
    pick_id    = '0;
    pick_pri   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (eligible[i] && (!pick_valid || src_pri[i] > pick_pri)) begin
        pick_valid = 1'b1;
        pick_id    = ID_W'(i);
        pick_pri   = src_pri[i];
      end
    end
  end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_accept_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_valid,
  input  logic [ID_W-1:0]   pick_id,
  input  logic [PRI_W-1:0]  pick_pri,
  input  logic              cpu_ack,
  output logic              accept,
  output logic [ID_W-1:0]   accept_id,
  output logic [VEC_W-1:0]  accept_vec,
  output logic [LVL_W-1:0]  new_mask,
  output logic              hold_off
);
  function automatic logic [VEC_W-1:0] vec_of(input logic [ID_W-1:0] id);
    return VEC_W'(VEC_BASE) + VEC_W'(id);
  endfunction

  logic take;
  assign take = pick_valid && !hold_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept     <= 1'b0;
      accept_id  <= '0;
      accept_vec <= '0;
      new_mask   <= '0;
      hold_off   <= 1'b0;
    end else begin
      accept <= take;
      if (take) begin
        accept_id  <= pick_id;
        accept_vec <= vec_of(pick_id);
        new_mask   <= mask_from_pri(pick_pri);
        hold_off   <= 1'b1;
      end else if (hold_off && cpu_ack) begin
        hold_off <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int N_EXT    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 8,
  localparam int N_SRC   = N_FIXED + N_EXT,
  localparam int ID_W    = $clog2(N_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    nmi_req,
  input  logic                    brk_req,
  input  logic                    dbg_req,
  input  logic [N_EXT-1:0]        ext_req,
  input  logic [N_EXT*LVL_W-1:0]  ext_lvl,
  input  logic [LVL_W-1:0]        sr_mask,
  input  logic                    cpu_ack,
  output logic                    accept,
  output logic [ID_W-1:0]         accept_id,
  output logic [VEC_W-1:0]        accept_vec,
  output logic [LVL_W-1:0]        new_mask
);
  logic [N_SRC-1:0]            src_req;
  logic [N_SRC-1:0][PRI_W-1:0] src_pri;
  logic                        pick_valid;
  logic [ID_W-1:0]             pick_id;
  logic [PRI_W-1:0]            pick_pri;
  logic                        hold_off;

  irq_src_map #(.N_EXT(N_EXT)) u_map (
    .nmi_req (nmi_req),
    .brk_req (brk_req),
    .dbg_req (dbg_req),
    .ext_req (ext_req),
    .ext_lvl (ext_lvl),
    .src_req (src_req),
    .src_pri (src_pri)
  );

  irq_prio_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick (
    .src_req    (src_req),
    .src_pri    (src_pri),
    .sr_mask    (sr_mask),
    .pick_valid (pick_valid),
    .pick_id    (pick_id),
    .pick_pri   (pick_pri)
  );

  irq_accept_seq #(.ID_W(ID_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (pick_valid),
    .pick_id    (pick_id),
    .pick_pri   (pick_pri),
    .cpu_ack    (cpu_ack),
    .accept     (accept),
    .accept_id  (accept_id),
    .accept_vec (accept_vec),
    .new_mask   (new_mask),
    .hold_off   (hold_off)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nmi_req,
  input logic [3:0]      sr_mask,
  input logic            accept,
  input logic [ID_W-1:0] accept_id,
  input logic [3:0]      new_mask,
  input logic            pick_valid,
  input logic            hold_off
);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  a_r11_no_accept_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($past(pick_valid) && !$past(hold_off)));

  a_r2_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $past(nmi_req)) |-> (accept_id == '0));

  a_r8_nmi_mask_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id == '0) |-> (new_mask == 4'hF));

  a_r4_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_id != '0) |-> (new_mask > $past(sr_mask)));

  a_r5_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (new_mask != 4'h0));
endmodule

bind irq_accept_ctrl irq_accept_chk #(.ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_req    (nmi_req),
  .sr_mask    (sr_mask),
  .accept     (accept),
  .accept_id  (accept_id),
  .new_mask   (new_mask),
  .pick_valid (pick_valid),
  .hold_off   (hold_off)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;
  localparam int N_EXT = 8;
  localparam int ID_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              nmi_req, brk_req, dbg_req, cpu_ack;
  logic [N_EXT-1:0]  ext_req;
  logic [N_EXT*4-1:0] ext_lvl;
  logic [3:0]        sr_mask;
  logic              accept;
  logic [ID_W-1:0]   accept_id;
  logic [7:0]        accept_vec;
  logic [3:0]        new_mask;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  irq_accept_ctrl #(.N_EXT(N_EXT)) dut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .brk_req(brk_req),
    .dbg_req(dbg_req), .ext_req(ext_req), .ext_lvl(ext_lvl),
    .sr_mask(sr_mask), .cpu_ack(cpu_ack), .accept(accept),
    .accept_id(accept_id), .accept_vec(accept_vec), .new_mask(new_mask)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_run = n_run + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_reqs();
    nmi_req = 0; brk_req = 0; dbg_req = 0; ext_req = '0;
  endtask

  task automatic set_ext(input int k, input logic [3:0] lvl);
    ext_req[k] = 1'b1;
    ext_lvl[k*4 +: 4] = lvl;
  endtask

  // Returns the block to the idle state after an acceptance.
  task automatic give_ack();
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  // Inputs were set at a falling edge; the result is due after the next rising edge.
  task automatic expect_accept(input string req, input int id, input int msk);
    @(negedge clk);
    check(req, "accept", int'(accept), 1);
    check(req, "accept_id", int'(accept_id), id);
    check(req, "accept_vec", int'(accept_vec), 8 + id);
    check(req, "new_mask", int'(new_mask), msk);
    clear_reqs();
    give_ack();
  endtask

  task automatic expect_none(input string req);
    @(negedge clk);
    check(req, "accept (1st)", int'(accept), 0);
    @(negedge clk);
    check(req, "accept (2nd)", int'(accept), 0);
    clear_reqs();
  endtask

  task automatic t_reset();
    check("R1", "accept", int'(accept), 0);
    check("R1", "accept_id", int'(accept_id), 0);
    check("R1", "accept_vec", int'(accept_vec), 0);
    check("R1", "new_mask", int'(new_mask), 0);
  endtask

  task automatic t_nmi();
    sr_mask = 4'hF; nmi_req = 1;
    expect_accept("R2/R8/R9 nmi at mask 15", 0, 15);
    sr_mask = 4'h0; nmi_req = 1; brk_req = 1; set_ext(0, 4'hF);
    expect_accept("R2/R7 nmi over level 15", 0, 15);
  endtask

  task automatic t_fixed();
    sr_mask = 4'hE; brk_req = 1;
    expect_accept("R3 breakpoint", 1, 15);
    sr_mask = 4'h3; dbg_req = 1;
    expect_accept("R3 debug port", 2, 15);
    sr_mask = 4'hF; brk_req = 1; dbg_req = 1;
    expect_none("R3 masked at 15");
  endtask

  task automatic t_ext_strict();
    sr_mask = 4'h5; set_ext(2, 4'h5);
    expect_none("R4 equal to mask");
    sr_mask = 4'h4; set_ext(2, 4'h5);
    expect_accept("R4/R8/R9 above mask", 5, 5);
  endtask

  task automatic t_zero();
    sr_mask = 4'h0; set_ext(0, 4'h0); set_ext(7, 4'h0);
    expect_none("R5 level zero");
  endtask

  task automatic t_highest();
    sr_mask = 4'h0; set_ext(1, 4'h3); set_ext(6, 4'h9); set_ext(4, 4'h7);
    expect_accept("R6 highest level", 9, 9);
    sr_mask = 4'h8; set_ext(1, 4'hC); set_ext(6, 4'h9);
    expect_accept("R6 highest other order", 4, 12);
  endtask

  task automatic t_tie();
    sr_mask = 4'h2; set_ext(5, 4'h6); set_ext(3, 4'h6);
    expect_accept("R7 tie external", 6, 6);
    sr_mask = 4'h0; dbg_req = 1; brk_req = 1; set_ext(7, 4'hF);
    expect_accept("R7 tie fixed sources", 1, 15);
    sr_mask = 4'h0; dbg_req = 1; set_ext(0, 4'hF);
    expect_accept("R7 debug over ext", 2, 15);
  endtask

  task automatic t_holdoff();
    sr_mask = 4'h1; set_ext(3, 4'hA);
    @(negedge clk);
    check("R10", "accept", int'(accept), 1);
    check("R10", "accept_id", int'(accept_id), 6);
    clear_reqs(); set_ext(1, 4'h4);
    @(negedge clk);
    check("R10 pulse ends", "accept", int'(accept), 0);
    check("R10 id held", "accept_id", int'(accept_id), 6);
    check("R10 mask held", "new_mask", int'(new_mask), 10);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R11 held without ack", "accept", int'(accept), 0);
    end
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    check("R11 edge sampling ack", "accept", int'(accept), 0);
    @(negedge clk);
    check("R11 after ack", "accept", int'(accept), 1);
    check("R11 after ack", "accept_id", int'(accept_id), 4);
    check("R11 after ack", "new_mask", int'(new_mask), 4);
    clear_reqs();
    give_ack();
  endtask

  initial begin
    rst_n = 1'b0; cpu_ack = 1'b0; sr_mask = 4'h0; ext_lvl = '0;
    clear_reqs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nmi();
    t_fixed();
    t_ext_strict();
    t_zero();
    t_highest();
    t_tie();
    t_holdoff();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule